// File: doc/BRIEF.md
# Four-Channel Serial Controller Register Block

This block is the register front end of a four-channel serial controller. A host reaches it through a simple single-cycle read/write port. For each channel it holds transmit and receive ring boundary registers. It also holds a channel enable mask, a per-channel active flag set and cleared by commands, an options register and a fixed command-response word. The ring boundaries and enables go out to the per-channel DMA engines. When a start register is written, the matching DMA engine gets a one-cycle pulse telling it to reload its current descriptor pointer from that start value.

The DMA engines report finished frames as single-cycle transmit and receive event pulses. The block collects these events in a pending status set. A status bit is visible only when its channel's matching enable bit is set. The visible bits drive a single interrupt line. A write of any value to the status address clears all pending status.

The command register understands two opcode dialects, selected by the `mode` input. The two dialects let two generations of host software drive the same hardware.

Top module: `serial_ctl_regs`

## Requirements
- R1: After reset every ring register, the enable mask, the options register, all pending status, all active flags, `busRdata`, the reload pulses and `irq` are zero.
- R2: Channel n (0..3) has a window at byte address 0x100*(n+1). Its transmit ring start is at window offset 0x80, transmit ring end at 0x84, receive ring start at 0x88 and receive ring end at 0x8C. Each register is 32 bits, reads back what was written and drives its slice n of the matching ring output bus.
- R3: A write to a channel's transmit (receive) ring start register raises bit n of `txCurLoad` (`rxCurLoad`) for exactly the one cycle after the write. Writes to end registers raise no reload pulse.
- R4: Address 0x14 is the channel enable mask. It holds 8 bits, and the upper read bits are zero. Bit 2n is channel n's transmit enable and bit 2n+1 is its receive enable. The mask drives `chanEnMask`.
- R5: A read of address 0x00 returns the status word. Bit n is set when channel n has a pending transmit event and transmit enable. Bit 4+n is set when channel n has a pending receive event and receive enable. All other bits are zero. A pending event stays stored while its enable bit is clear.
- R6: A write of any data to address 0x00 clears all pending status. An event pulse arriving in the same cycle as the clear is kept.
- R7: A write to 0x2C24 is a command. The opcode is data bits 19:12 and the channel is data bits 1:0. With `mode`=0, opcode 0x00 sets and 0x10 clears that channel's bit in `chanActive`.
- R8: With `mode`=1, opcode 0x00 sets the channel's active bit, and opcodes 0x50 and 0x30 clear it.
- R9: Command opcodes other than those in R7/R8 leave `chanActive` unchanged, and so do writes to any other address.
- R10: Address 0x2C2C always reads 0x0000FFFF. Address 0x2C00 is a 32-bit read/write options register.
- R11: Reads of unmapped addresses return zero. This includes the command address, unused window offsets and addresses at or above 0x500 outside the listed ones. Writes to them change no register.
- R12: `irq` is high exactly when some status bit of R5 is visible. It stays high until a clear or a mask change hides every bit.
- R13: Read data appears on `busRdata` in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 1 | Command dialect select (0 or 1) |
| busSel | input | 1 | Register access request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 14 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| txEvent | input | 4 | Per-channel transmit-done pulse |
| rxEvent | input | 4 | Per-channel receive-done pulse |
| txRingStart | output | 128 | Transmit ring start, 32 bits per channel |
| txRingEnd | output | 128 | Transmit ring end, 32 bits per channel |
| rxRingStart | output | 128 | Receive ring start, 32 bits per channel |
| rxRingEnd | output | 128 | Receive ring end, 32 bits per channel |
| txCurLoad | output | 4 | Transmit current-pointer reload pulse |
| rxCurLoad | output | 4 | Receive current-pointer reload pulse |
| chanEnMask | output | 8 | Enable mask bits |
| chanActive | output | 4 | Per-channel active flags |
| irq | output | 1 | Interrupt request |

## Verification
Every result lands exactly one clock edge after its stimulus. This covers register contents and ring outputs after a write, read data after a read, reload pulses and active flags after a write, and pending status and `irq` after an event or a clear. The bench drives on the falling edge and samples on the next falling edge, so each check reads the value registered by the single rising edge in between. Reload pulses are also sampled one cycle later to confirm they last exactly one cycle. The mask space, the full opcode space in both modes and every ring register are swept, and the expected values are computed from the bit positions stated in the requirements.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
  localparam int CH_NUM   = 4;
  localparam int CH_IDX_W = $clog2(CH_NUM);

  typedef enum logic [3:0] {
    RD_NONE, RD_STATUS, RD_MASK, RD_OPTS, RD_RESP,
    RD_TXS, RD_TXE, RD_RXS, RD_RXE
  } rdSel_e;

  typedef struct packed {
    logic [CH_NUM-1:0]   wrTxStart;
    logic [CH_NUM-1:0]   wrTxEnd;
    logic [CH_NUM-1:0]   wrRxStart;
    logic [CH_NUM-1:0]   wrRxEnd;
    logic                wrMask;
    logic                wrOpts;
    logic                clrStatus;
    logic                chanOn;
    logic                chanOff;
    logic [CH_IDX_W-1:0] cmdChan;
    logic                rdEn;
    rdSel_e              rdSel;
    logic [CH_IDX_W-1:0] rdChan;
  } strobe_t;
endpackage

// File: rtl/serial_regs_ctl.sv
module serial_regs_ctl
  import serial_regs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input  logic              mode,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           st
);
  localparam int WIN_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'('h0000);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'('h0014);
  localparam logic [ADDR_W-1:0] A_OPTS   = ADDR_W'('h2C00);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'('h2C24);
  localparam logic [ADDR_W-1:0] A_RESP   = ADDR_W'('h2C2C);

  logic             isWr, isRd, chanHit;
  logic [WIN_W-1:0] winSel;
  logic [CH_IDX_W-1:0] chanIdx;
  logic [7:0]       winOff, opCode;
  logic             opEnable, opDisable;

  assign isWr    = busSel && busWr;
  assign isRd    = busSel && !busWr;
  assign winSel  = busAddr[ADDR_W-1:8];
  assign winOff  = busAddr[7:0];
  assign chanHit = (winSel >= WIN_W'(1)) && (winSel <= WIN_W'(CH_NUM));
  assign chanIdx = CH_IDX_W'(winSel - WIN_W'(1));
  assign opCode  = busWdata[19:12];

  // opcode dialect chosen by mode
  always_comb begin
    opEnable  = (opCode == 8'h00);
    opDisable = 1'b0;
    if (mode) opDisable = (opCode == 8'h50) || (opCode == 8'h30);
    else      opDisable = (opCode == 8'h10);
  end

  always_comb begin
    st        = '0;
    st.rdSel  = RD_NONE;
    st.rdEn   = isRd;
    st.rdChan = chanIdx;
    st.cmdChan = busWdata[CH_IDX_W-1:0];
    if (chanHit) begin
      unique case (winOff)
        8'h80: begin st.rdSel = RD_TXS; st.wrTxStart[chanIdx] = isWr; end
        8'h84: begin st.rdSel = RD_TXE; st.wrTxEnd[chanIdx]   = isWr; end
        8'h88: begin st.rdSel = RD_RXS; st.wrRxStart[chanIdx] = isWr; end
        8'h8C: begin st.rdSel = RD_RXE; st.wrRxEnd[chanIdx]   = isWr; end
        default: st.rdSel = RD_NONE;
      endcase
    end else begin
      unique case (busAddr)
        A_STATUS: begin st.rdSel = RD_STATUS; st.clrStatus = isWr; end
        A_MASK:   begin st.rdSel = RD_MASK;   st.wrMask    = isWr; end
        A_OPTS:   begin st.rdSel = RD_OPTS;   st.wrOpts    = isWr; end
        A_RESP:   st.rdSel = RD_RESP;
        A_CMD: begin
          st.chanOn  = isWr && opEnable;
          st.chanOff = isWr && opDisable;
        end
        default: st.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/serial_regs_dp.sv
module serial_regs_dp
  import serial_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  st,
  input  logic [DATA_W-1:0]        busWdata,
  input  logic [CH_NUM-1:0]        txEvent,
  input  logic [CH_NUM-1:0]        rxEvent,
  output logic [CH_NUM*DATA_W-1:0] txRingStart,
  output logic [CH_NUM*DATA_W-1:0] txRingEnd,
  output logic [CH_NUM*DATA_W-1:0] rxRingStart,
  output logic [CH_NUM*DATA_W-1:0] rxRingEnd,
  output logic [CH_NUM-1:0]        txCurLoad,
  output logic [CH_NUM-1:0]        rxCurLoad,
  output logic [2*CH_NUM-1:0]      chanEnMask,
  output logic [CH_NUM-1:0]        chanActive,
  output logic                     irq,
  output logic [DATA_W-1:0]        busRdata
);
  localparam int MASK_W = 2 * CH_NUM;
  localparam logic [DATA_W-1:0] RESP_WORD = DATA_W'('hFFFF);

  logic [DATA_W-1:0] txS [CH_NUM];
  logic [DATA_W-1:0] txE [CH_NUM];
  logic [DATA_W-1:0] rxS [CH_NUM];
  logic [DATA_W-1:0] rxE [CH_NUM];
  logic [CH_NUM-1:0] txPend, rxPend, txVis, rxVis;
  logic [MASK_W-1:0] maskReg;
  logic [DATA_W-1:0] optsReg, rdMux;

  for (genvar i = 0; i < CH_NUM; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        txS[i] <= '0; txE[i] <= '0; rxS[i] <= '0; rxE[i] <= '0;
        txCurLoad[i] <= 1'b0; rxCurLoad[i] <= 1'b0;
        txPend[i] <= 1'b0; rxPend[i] <= 1'b0;
      end else begin
        if (st.wrTxStart[i]) txS[i] <= busWdata;
        if (st.wrTxEnd[i])   txE[i] <= busWdata;
        if (st.wrRxStart[i]) rxS[i] <= busWdata;
        if (st.wrRxEnd[i])   rxE[i] <= busWdata;
        txCurLoad[i] <= st.wrTxStart[i];
        rxCurLoad[i] <= st.wrRxStart[i];
        if (txEvent[i])        txPend[i] <= 1'b1;
        else if (st.clrStatus) txPend[i] <= 1'b0;
        if (rxEvent[i])        rxPend[i] <= 1'b1;
        else if (st.clrStatus) rxPend[i] <= 1'b0;
      end
    end
    assign txVis[i] = txPend[i] && maskReg[2*i];
    assign rxVis[i] = rxPend[i] && maskReg[2*i+1];
    assign txRingStart[i*DATA_W +: DATA_W] = txS[i];
    assign txRingEnd[i*DATA_W +: DATA_W]   = txE[i];
    assign rxRingStart[i*DATA_W +: DATA_W] = rxS[i];
    assign rxRingEnd[i*DATA_W +: DATA_W]   = rxE[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg    <= '0;
      optsReg    <= '0;
      chanActive <= '0;
    end else begin
      if (st.wrMask)  maskReg <= busWdata[MASK_W-1:0];
      if (st.wrOpts)  optsReg <= busWdata;
      if (st.chanOn)  chanActive[st.cmdChan] <= 1'b1;
      if (st.chanOff) chanActive[st.cmdChan] <= 1'b0;
    end
  end

  always_comb begin
    unique case (st.rdSel)
      RD_STATUS: rdMux = DATA_W'({rxVis, txVis});
      RD_MASK:   rdMux = DATA_W'(maskReg);
      RD_OPTS:   rdMux = optsReg;
      RD_RESP:   rdMux = RESP_WORD;
      RD_TXS:    rdMux = txS[st.rdChan];
      RD_TXE:    rdMux = txE[st.rdChan];
      RD_RXS:    rdMux = rxS[st.rdChan];
      RD_RXE:    rdMux = rxE[st.rdChan];
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        busRdata <= '0;
    else if (st.rdEn) busRdata <= rdMux;
  end

  assign chanEnMask = maskReg;
  assign irq        = |{rxVis, txVis};
endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import serial_regs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     mode,
  input  logic                     busSel,
  input  logic                     busWr,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  input  logic [CH_NUM-1:0]        txEvent,
  input  logic [CH_NUM-1:0]        rxEvent,
  output logic [CH_NUM*DATA_W-1:0] txRingStart,
  output logic [CH_NUM*DATA_W-1:0] txRingEnd,
  output logic [CH_NUM*DATA_W-1:0] rxRingStart,
  output logic [CH_NUM*DATA_W-1:0] rxRingEnd,
  output logic [CH_NUM-1:0]        txCurLoad,
  output logic [CH_NUM-1:0]        rxCurLoad,
  output logic [2*CH_NUM-1:0]      chanEnMask,
  output logic [CH_NUM-1:0]        chanActive,
  output logic                     irq
);
  strobe_t st;

  serial_regs_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .mode(mode), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .st(st)
  );

  serial_regs_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .busWdata(busWdata),
    .txEvent(txEvent), .rxEvent(rxEvent),
    .txRingStart(txRingStart), .txRingEnd(txRingEnd),
    .rxRingStart(rxRingStart), .rxRingEnd(rxRingEnd),
    .txCurLoad(txCurLoad), .rxCurLoad(rxCurLoad),
    .chanEnMask(chanEnMask), .chanActive(chanActive),
    .irq(irq), .busRdata(busRdata)
  );
endmodule

// File: rtl/serial_ctl_regs_chk.sv
module serial_ctl_regs_chk
  import serial_regs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     mode,
  input logic                     busSel,
  input logic                     busWr,
  input logic [ADDR_W-1:0]        busAddr,
  input logic [DATA_W-1:0]        busWdata,
  input logic [DATA_W-1:0]        busRdata,
  input logic [CH_NUM-1:0]        txEvent,
  input logic [CH_NUM-1:0]        rxEvent,
  input logic [CH_NUM*DATA_W-1:0] txRingStart,
  input logic [CH_NUM*DATA_W-1:0] txRingEnd,
  input logic [CH_NUM*DATA_W-1:0] rxRingStart,
  input logic [CH_NUM*DATA_W-1:0] rxRingEnd,
  input logic [CH_NUM-1:0]        txCurLoad,
  input logic [CH_NUM-1:0]        rxCurLoad,
  input logic [2*CH_NUM-1:0]      chanEnMask,
  input logic [CH_NUM-1:0]        chanActive,
  input logic                     irq
);
  logic wrStatus, wrMaskAddr, anyEvent;
  assign wrStatus   = busSel && busWr && (busAddr == ADDR_W'('h0000));
  assign wrMaskAddr = busSel && busWr && (busAddr == ADDR_W'('h0014));
  assign anyEvent   = |{txEvent, rxEvent};

  // R12: interrupt holds until a clear or a mask change
  a_r12_irq_holds: assert property (@(posedge clk) disable iff (!rstN)
    irq && !wrStatus && !wrMaskAddr |=> irq);

  // R6: clear with no concurrent event drops irq
  a_r6_clear_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    wrStatus && !anyEvent |=> !irq);

  // R3: reload pulses only follow a bus write
  a_r3_load_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (|{txCurLoad, rxCurLoad}) |-> $past(busSel && busWr));

  // R9: active flags move only on a write
  a_r9_active_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr) |=> $stable(chanActive));

  // R13: read data holds without a read
  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr) |=> $stable(busRdata));

  // R5: status word uses only its low eight bits
  a_r5_status_width: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWr && (busAddr == ADDR_W'('h0000)) |=> busRdata[DATA_W-1:8] == '0);
endmodule

bind serial_ctl_regs serial_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_serial_ctl_regs.sv
`timescale 1ns/1ps
module test_serial_ctl_regs;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         mode = 1'b0;
  logic         busSel = 1'b0, busWr = 1'b0;
  logic [13:0]  busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [3:0]   txEvent = '0, rxEvent = '0;
  logic [127:0] txRingStart, txRingEnd, rxRingStart, rxRingEnd;
  logic [3:0]   txCurLoad, rxCurLoad, chanActive;
  logic [7:0]   chanEnMask;
  logic         irq;

  int tests = 0, fails = 0;
  logic [3:0] txP = '0, rxP = '0, expAct = '0;
  logic [3:0] loadTx, loadRx;

  always #10 clk = ~clk;

  serial_ctl_regs i_serial_ctl_regs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
    loadTx = txCurLoad; loadRx = rxCurLoad;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a;
    @(negedge clk); busSel = 0; d = busRdata;
  endtask

  task automatic pulse(input logic [3:0] t, input logic [3:0] r);
    @(negedge clk); txEvent = t; rxEvent = r;
    @(negedge clk); txEvent = '0; rxEvent = '0;
    txP |= t; rxP |= r;
  endtask

  function automatic logic [31:0] expStatus(input logic [7:0] m);
    logic [31:0] e = '0;
    for (int n = 0; n < 4; n++) begin
      if (txP[n] && m[2*n])   e[n]   = 1'b1;
      if (rxP[n] && m[2*n+1]) e[4+n] = 1'b1;
    end
    return e;
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d, v;
    logic [13:0] base;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 active", {28'b0, chanActive}, 0);
    chk("R1 rings", {txRingStart[31:0] | rxRingEnd[127:96]}, 0);
    chk("R1 loads", {24'b0, txCurLoad, rxCurLoad}, 0);
    chk("R1 rdata", busRdata, 0);
    rd(14'h0014, d); chk("R1 mask", d, 0);
    rd(14'h2C00, d); chk("R1 opts", d, 0);

    // R2 / R3 ring register sweep
    for (int ch = 0; ch < 4; ch++) begin
      for (int r = 0; r < 4; r++) begin
        base = 14'((ch + 1) * 'h100 + 'h80 + r * 4);
        v = 32'hC000_0000 ^ (ch << 20) ^ (r << 12) ^ 32'h0000_5A5C;
        wr(base, v);
        chk("R3 tx load pulse", {28'b0, loadTx}, (r == 0) ? (1 << ch) : 0);
        chk("R3 rx load pulse", {28'b0, loadRx}, (r == 2) ? (1 << ch) : 0);
        @(negedge clk);
        chk("R3 pulse one cycle", {24'b0, txCurLoad, rxCurLoad}, 0);
        rd(base, d); chk("R2 readback", d, v);
        case (r)
          0: chk("R2 tx start out", txRingStart[ch*32 +: 32], v);
          1: chk("R2 tx end out",   txRingEnd[ch*32 +: 32], v);
          2: chk("R2 rx start out", rxRingStart[ch*32 +: 32], v);
          default: chk("R2 rx end out", rxRingEnd[ch*32 +: 32], v);
        endcase
      end
    end

    // R5 / R4 / R12 mask sweep with all pending
    pulse(4'hF, 4'hF);
    for (int m = 0; m < 256; m++) begin
      wr(14'h0014, 32'hFFFF_FF00 | m);
      chk("R4 mask out", {24'b0, chanEnMask}, m);
      rd(14'h0000, d); chk("R5 status", d, expStatus(8'(m)));
      chk("R12 irq", {31'b0, irq}, {31'b0, expStatus(8'(m)) != 0});
    end
    rd(14'h0014, d); chk("R4 mask readback", d, 32'hFF);

    // R6 clear, then partial patterns
    wr(14'h0000, 32'h1234_5678); txP = 0; rxP = 0;
    chk("R6 irq after clear", {31'b0, irq}, 0);
    rd(14'h0000, d); chk("R6 status cleared", d, 0);
    for (int p = 1; p < 16; p++) begin
      pulse(4'(p), 4'(~p));
      chk("R12 irq after event", {31'b0, irq}, 1);
      rd(14'h0000, d); chk("R5 pattern", d, expStatus(8'hFF));
      wr(14'h0000, 0); txP = 0; rxP = 0;
      rd(14'h0000, d); chk("R6 pattern cleared", d, 0);
    end
    // R5 hidden event stays pending
    wr(14'h0014, 32'h0);
    pulse(4'h4, 4'h0);
    chk("R12 hidden irq", {31'b0, irq}, 0);
    wr(14'h0014, 32'h10);
    chk("R5 revealed irq", {31'b0, irq}, 1);
    rd(14'h0000, d); chk("R5 revealed status", d, 32'h4);
    // R6 event coincident with clear survives
    wr(14'h0014, 32'hFF);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = 14'h0000; rxEvent = 4'h2;
    @(negedge clk); busSel = 0; busWr = 0; rxEvent = 0;
    txP = 0; rxP = 4'h2;
    rd(14'h0000, d); chk("R6 concurrent event kept", d, 32'h20);
    wr(14'h0000, 0); txP = 0; rxP = 0;

    // R7 / R8 / R9 opcode sweep in both modes
    for (int md = 0; md < 2; md++) begin
      mode = md[0];
      for (int op = 0; op < 256; op++) begin
        int ch = op % 4;
        logic isOff;
        wr(14'h2C24, 32'h0000_0000 | ch);
        expAct[ch] = 1'b1;
        wr(14'h2C24, (32'(op ^ 'hA5) << 20) | (32'(op) << 12) | (32'(op) << 2) | ch);
        isOff = (md == 0) ? (op == 'h10) : (op == 'h50 || op == 'h30);
        if (isOff) expAct[ch] = 1'b0;
        if (md == 0) chk("R7 mode0 command", {28'b0, chanActive}, {28'b0, expAct});
        else         chk("R8 mode1 command", {28'b0, chanActive}, {28'b0, expAct});
      end
    end
    rd(14'h2C24, d); chk("R11 command reads zero", d, 0);

    // R10 response and options
    rd(14'h2C2C, d); chk("R10 response", d, 32'h0000_FFFF);
    wr(14'h2C2C, 32'h0);
    rd(14'h2C2C, d); chk("R10 response fixed", d, 32'h0000_FFFF);
    wr(14'h2C00, 32'hDEAD_BEEF);
    rd(14'h2C00, d); chk("R10 options", d, 32'hDEAD_BEEF);

    // R11 unmapped addresses and R9 no side effects
    begin
      logic [13:0] um [8] = '{14'h0004, 14'h0010, 14'h2C28, 14'h0190,
                              14'h0500, 14'h3FFC, 14'h0182, 14'h0080};
      for (int k = 0; k < 8; k++) begin
        wr(um[k], 32'hFFFF_FFFF);
        rd(um[k], d); chk("R11 unmapped read", d, 0);
      end
    end
    chk("R9 active after junk writes", {28'b0, chanActive}, {28'b0, expAct});
    rd(14'h0014, d); chk("R11 mask untouched", d, 32'hFF);
    rd(14'h2C00, d); chk("R11 options untouched", d, 32'hDEAD_BEEF);
    rd(14'h0180, d);
    chk("R11 ring untouched", d, 32'hC000_0000 ^ (0 << 20) ^ (0 << 12) ^ 32'h0000_5A5C);

    // R13 read data holds
    rd(14'h2C2C, d);
    wr(14'h2C00, 32'h1);
    repeat (3) @(negedge clk);
    chk("R13 rdata hold", busRdata, 32'h0000_FFFF);

    finish_run();
  end
endmodule